// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block gives a small 8-bit processor core its data memory. A 12-bit address space is cut into sixteen pages of 256 bytes. An 8-bit page register names the page that ordinary direct accesses use. Each cycle the unit builds one 12-bit address from one of three sources. The first is the page register joined to the 8-bit offset from the instruction. The second is a fixed shared window, chosen by an instruction bit, that ignores the page register. The third is a complete 12-bit address that the instruction carries, used by memory-to-memory moves.

The storage is static RAM with one read/write port. Only the lowest `NUM_BANKS` pages exist. A page at or above that count reads as zero and ignores writes, and it never aliases onto a real page. Reads are synchronous: the data for an address shows up one cycle after the address is presented. A load of the page register takes effect on the following cycle.

Top module: `bdm_unit`

## Requirements
- R1: After reset the page register reads back 00h and `rd_data` is 00h.
- R2: When `bank_load` is high, the page register takes the literal's low 4 bits at the clock edge; its upper 4 bits always read 0; when `bank_load` is low it keeps its value.
- R3: With `move_en` and `access_en` low, `mem_addr` is {page register bits 3..0, `offset`}; a page load in the same cycle affects only later cycles.
- R4: With `access_en` high and `move_en` low, `mem_addr` is {0h, `offset`} when `offset` is below 80h, and {Fh, `offset`} otherwise.
- R5: With `move_en` high, `mem_addr` equals `move_addr`, whatever the page register, `access_en` or `offset` hold.
- R6: When `wr_en` is high and the page of `mem_addr` is below `NUM_BANKS`, `wr_data` is stored at `mem_addr` on that clock edge.
- R7: `rd_data` shows the byte stored at the address of the previous cycle; a write to that same address in that cycle is not yet visible, so the old byte is returned.
- R8: For a page at or above `NUM_BANKS`, `rd_data` in the following cycle is 00h and a write is discarded; the byte at the same offset of page 0 is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| bank_load | input | 1 | Load the page register from `bank_lit` |
| bank_lit | input | 8 | Literal for the page register |
| access_en | input | 1 | Use the shared window instead of the page register |
| move_en | input | 1 | Use the full address `move_addr` |
| move_addr | input | 12 | Full 12-bit address for moves |
| offset | input | 8 | In-page offset from the instruction |
| wr_en | input | 1 | Write `wr_data` at `mem_addr` |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, one cycle after the address |
| mem_addr | output | 12 | Address formed this cycle |
| bank_rd | output | 8 | Page register read-back |

## Verification
Two pairs of events can fall in the same cycle, and both are provoked on purpose. The first is a page load together with a direct write. The bench expects the write to land in the old page, and expects the new page only in the address of the next vector. The second is a read and a write to the same address in one cycle. The bench expects `rd_data` to show the byte from before the write, and the new byte one vector later.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
    localparam int DATA_W = 8;
    localparam int OFF_W  = 8;
    localparam int BANK_W = 4;
    localparam int REG_W  = 8;
    localparam int ADDR_W = BANK_W + OFF_W;

    typedef enum logic [1:0] {
        SRC_BANKED = 2'd0,
        SRC_ACCESS = 2'd1,
        SRC_FULL   = 2'd2
    } src_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [OFF_W-1:0]  off;
    } daddr_t;
endpackage

// File: rtl/bdm_bank_reg.sv
module bdm_bank_reg
    import bdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REG_W-1:0] lit,
    output logic [REG_W-1:0] bank_o
);
    localparam logic [REG_W-1:0] KEEP_MASK = REG_W'((1 << BANK_W) - 1);

    typedef struct packed {
        logic [REG_W-1:0] val;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.val = lit & KEEP_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_o = st_q.val;

    // R2: upper bits never hold a one
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bank_o[REG_W-1:BANK_W] == '0);

    // R2: a load lands on the next edge
    p_load_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> bank_o[BANK_W-1:0] == $past(lit[BANK_W-1:0]));

    // R2: no load, no change
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(bank_o));
endmodule

// File: rtl/bdm_addr_sel.sv
module bdm_addr_sel
    import bdm_pkg::*;
#(
    parameter logic [OFF_W-1:0] ACC_SPLIT = 8'h80
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [OFF_W-1:0]  offset,
    input  logic              access_en,
    input  logic              move_en,
    input  logic [ADDR_W-1:0] move_addr,
    output daddr_t            addr_o
);
    src_e src;

    always_comb begin
        if (move_en) begin
            src = SRC_FULL;
        end else if (access_en) begin
            src = SRC_ACCESS;
        end else begin
            src = SRC_BANKED;
        end
    end

    always_comb begin
        addr_o.off = offset;
        unique case (src)
            SRC_FULL: begin
                addr_o = daddr_t'(move_addr);
            end
            SRC_ACCESS: begin
                addr_o.bank = (offset < ACC_SPLIT) ? '0 : '1;
            end
            default: begin
                addr_o.bank = bank;
            end
        endcase
    end
endmodule

// File: rtl/bdm_ram_bank.sv
module bdm_ram_bank
    import bdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << OFF_W;

    logic [DATA_W-1:0] mem [DEPTH];

    typedef struct packed {
        logic [DATA_W-1:0] rd;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel) begin
            st_d.rd = mem[off];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (sel && wr_en) begin
            mem[off] <= wdata;
        end
    end

    assign rdata = st_q.rd;

    // R7: output changes only for a selected read
    p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(rdata));
endmodule

// File: rtl/bdm_ram_array.sv
module bdm_ram_array
    import bdm_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  daddr_t            addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [BANK_W:0] NB_L = NUM_BANKS[BANK_W:0];

    typedef struct packed {
        logic [BANK_W-1:0] rsel;
        logic              rimpl;
    } st_t;

    st_t st_d, st_q;
    logic impl;
    logic [DATA_W-1:0] bank_rd [NUM_BANKS];

    assign impl = ({1'b0, addr.bank} < NB_L);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic sel_g;
        assign sel_g = impl && (addr.bank == BANK_W'(g));
        bdm_ram_bank u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (sel_g),
            .wr_en (wr_en),
            .off   (addr.off),
            .wdata (wdata),
            .rdata (bank_rd[g])
        );
    end

    always_comb begin
        st_d.rsel  = addr.bank;
        st_d.rimpl = impl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int g = 0; g < NUM_BANKS; g++) begin
            if (st_q.rimpl && (st_q.rsel == BANK_W'(g))) begin
                rdata = bank_rd[g];
            end
        end
    end

    // R8: a missing page reads zero in the next cycle
    p_unimpl_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !({1'b0, addr.bank} < NB_L) |=> rdata == '0);
endmodule

// File: rtl/bdm_unit.sv
module bdm_unit
    import bdm_pkg::*;
#(
    parameter int               NUM_BANKS = 4,
    parameter logic [OFF_W-1:0] ACC_SPLIT = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_load,
    input  logic [REG_W-1:0]  bank_lit,
    input  logic              access_en,
    input  logic              move_en,
    input  logic [ADDR_W-1:0] move_addr,
    input  logic [OFF_W-1:0]  offset,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [REG_W-1:0]  bank_rd
);
    logic [REG_W-1:0] bank_q;
    daddr_t           addr;

    bdm_bank_reg u_bank_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (bank_load),
        .lit    (bank_lit),
        .bank_o (bank_q)
    );

    bdm_addr_sel #(.ACC_SPLIT(ACC_SPLIT)) u_addr_sel (
        .bank      (bank_q[BANK_W-1:0]),
        .offset    (offset),
        .access_en (access_en),
        .move_en   (move_en),
        .move_addr (move_addr),
        .addr_o    (addr)
    );

    bdm_ram_array #(.NUM_BANKS(NUM_BANKS)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wr_en (wr_en),
        .wdata (wr_data),
        .rdata (rd_data)
    );

    assign mem_addr = addr;
    assign bank_rd  = bank_q;

    // R3: direct path uses the page register
    p_direct_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!move_en && !access_en) |-> mem_addr[ADDR_W-1:OFF_W] == bank_rd[BANK_W-1:0]);

    // R4: shared window, low half
    p_access_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!move_en && access_en && offset < ACC_SPLIT) |-> mem_addr[ADDR_W-1:OFF_W] == '0);

    // R4: shared window, high half
    p_access_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!move_en && access_en && offset >= ACC_SPLIT) |-> mem_addr[ADDR_W-1:OFF_W] == '1);

    // R5: full address bypass
    p_move_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        move_en |-> mem_addr == move_addr);
endmodule

// File: tb/bdm_unit_test.sv
module bdm_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_load = 1'b0;
    logic [7:0]  bank_lit = '0;
    logic        access_en = 1'b0;
    logic        move_en = 1'b0;
    logic [11:0] move_addr = '0;
    logic [7:0]  offset = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [11:0] mem_addr;
    logic [7:0]  bank_rd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bdm_unit #(.NUM_BANKS(4)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_load (bank_load),
        .bank_lit  (bank_lit),
        .access_en (access_en),
        .move_en   (move_en),
        .move_addr (move_addr),
        .offset    (offset),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .mem_addr  (mem_addr),
        .bank_rd   (bank_rd)
    );

    typedef struct packed {
        logic        ld;
        logic [7:0]  lit;
        logic        acc;
        logic        mv;
        logic [11:0] ma;
        logic [7:0]  off;
        logic        we;
        logic [7:0]  wd;
        logic [11:0] ea;
        logic        chk;
        logic [7:0]  er;
        logic [7:0]  eb;
    } vec_t;

    localparam int NV = 16;
    // ld lit acc mv ma off we wd | exp addr, check rd, exp rd, exp page after
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'hA2, 1'b0, 1'b0, 12'h000, 8'h10, 1'b1, 8'h11, 12'h010, 1'b0, 8'h00, 8'h02}, // R3 same-cycle load, R2
        '{1'b0, 8'h00, 1'b0, 1'b0, 12'h000, 8'h10, 1'b1, 8'h22, 12'h210, 1'b0, 8'h00, 8'h02}, // R3, R6
        '{1'b0, 8'h00, 1'b0, 1'b0, 12'h000, 8'h10, 1'b0, 8'h00, 12'h210, 1'b1, 8'h22, 8'h02}, // R7
        '{1'b0, 8'h00, 1'b1, 1'b0, 12'h000, 8'h10, 1'b0, 8'h00, 12'h010, 1'b1, 8'h11, 8'h02}, // R4 low
        '{1'b0, 8'h00, 1'b1, 1'b1, 12'h010, 8'h55, 1'b0, 8'h00, 12'h010, 1'b1, 8'h11, 8'h02}, // R5
        '{1'b0, 8'h00, 1'b0, 1'b1, 12'h210, 8'h00, 1'b1, 8'h33, 12'h210, 1'b1, 8'h22, 8'h02}, // R7 old data
        '{1'b0, 8'h00, 1'b0, 1'b0, 12'h000, 8'h10, 1'b0, 8'h00, 12'h210, 1'b1, 8'h33, 8'h02}, // R6
        '{1'b1, 8'hF4, 1'b0, 1'b0, 12'h000, 8'h10, 1'b0, 8'h00, 12'h210, 1'b1, 8'h33, 8'h04}, // R2 mask
        '{1'b0, 8'h00, 1'b0, 1'b0, 12'h000, 8'h10, 1'b1, 8'h99, 12'h410, 1'b1, 8'h00, 8'h04}, // R8
        '{1'b0, 8'h00, 1'b0, 1'b0, 12'h000, 8'h10, 1'b0, 8'h00, 12'h410, 1'b1, 8'h00, 8'h04}, // R8
        '{1'b0, 8'h00, 1'b0, 1'b1, 12'h010, 8'h00, 1'b0, 8'h00, 12'h010, 1'b1, 8'h11, 8'h04}, // R8 no alias
        '{1'b0, 8'h00, 1'b1, 1'b0, 12'h000, 8'h90, 1'b1, 8'h77, 12'hF90, 1'b1, 8'h00, 8'h04}, // R4 high, R8
        '{1'b0, 8'h00, 1'b1, 1'b0, 12'h000, 8'h7F, 1'b1, 8'h44, 12'h07F, 1'b0, 8'h00, 8'h04}, // R4 edge
        '{1'b0, 8'h00, 1'b1, 1'b0, 12'h000, 8'h7F, 1'b0, 8'h00, 12'h07F, 1'b1, 8'h44, 8'h04}, // R6
        '{1'b1, 8'h03, 1'b0, 1'b1, 12'h3FF, 8'h00, 1'b1, 8'h5A, 12'h3FF, 1'b0, 8'h00, 8'h03}, // R5, R2
        '{1'b0, 8'h00, 1'b0, 1'b0, 12'h000, 8'hFF, 1'b0, 8'h00, 12'h3FF, 1'b1, 8'h5A, 8'h03}  // R3, R6
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        bank_load = v.ld;
        bank_lit  = v.lit;
        access_en = v.acc;
        move_en   = v.mv;
        move_addr = v.ma;
        offset    = v.off;
        wr_en     = v.we;
        wr_data   = v.wd;
    endtask

    task automatic idle();
        bank_load = 1'b0;
        access_en = 1'b0;
        move_en   = 1'b0;
        wr_en     = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 page after reset", 32'(bank_rd), 32'h00);
        check("R1 rd_data after reset", 32'(rd_data), 32'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 page held idle", 32'(bank_rd), 32'h00);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            #1;
            check($sformatf("R3/R4/R5 addr vec %0d", i), 32'(mem_addr), 32'(VEC[i].ea));
            @(negedge clk);
            if (VEC[i].chk) begin
                check($sformatf("R6/R7/R8 rd vec %0d", i), 32'(rd_data), 32'(VEC[i].er));
            end
            check($sformatf("R2 page vec %0d", i), 32'(bank_rd), 32'(VEC[i].eb));
        end

        // R5: bypass ignores a nonzero page and an active window bit
        idle();
        move_en = 1'b1; access_en = 1'b1; offset = 8'hC3; move_addr = 12'h1AB;
        #1;
        check("R5 bypass ignores page", 32'(mem_addr), 32'h1AB);
        @(negedge clk);

        // R1: reset again, memory contents survive, outputs clear
        idle();
        rst_n = 1'b0;
        #1;
        check("R1 page cleared", 32'(bank_rd), 32'h00);
        check("R1 rd cleared", 32'(rd_data), 32'h00);
        @(negedge clk);
        rst_n = 1'b1;
        offset = 8'h10;
        #1;
        check("R3 direct after reset", 32'(mem_addr), 32'h010);
        @(negedge clk);
        check("R6 data kept over reset", 32'(rd_data), 32'h11);

        // R8: dropped write must not reach page 0 or page 2
        bank_load = 1'b1; bank_lit = 8'h07;
        @(negedge clk);
        bank_load = 1'b0; wr_en = 1'b1; wr_data = 8'hEE; offset = 8'h10;
        #1;
        check("R8 addr in missing page", 32'(mem_addr), 32'h710);
        @(negedge clk);
        wr_en = 1'b0; move_en = 1'b1; move_addr = 12'h010;
        @(negedge clk);
        check("R8 page 0 untouched", 32'(rd_data), 32'h11);
        move_addr = 12'h210;
        @(negedge clk);
        check("R8 page 2 untouched", 32'(rd_data), 32'h33);
        idle();

        done = 1;
        finish_run();
    end
endmodule